// File: doc/BRIEF.md
# Slewed Time-of-Day Counter with Interpolated Reads

This block holds the local time of day as a seconds count plus a nanosecond field that carries a binary fraction. It moves forward only on a tick strobe. Each tick adds three terms: a fixed nominal step of exactly 2^-TICK_SHIFT seconds, a share of the outstanding phase error, and a per-tick frequency correction. The outstanding phase error is reduced by the amount applied, so a phase offset decays exponentially over many ticks and the time never jumps. The frequency correction is spread evenly over the ticks of one second. It is refreshed only when the nanosecond field wraps into a new second.

An external loop filter, which is not part of this block, writes a phase offset, a frequency offset and a time constant through a load strobe. The loaded values wait until the next tick. A read strobe returns a full time value one clock later. That value is the tick-aligned time plus an interpolation from a counter of clock cycles since the last tick, scaled to nanoseconds and capped at one nominal tick. Returned values never go backward.

Top module: `tod_disc_clock`

## Requirements
- R1: After reset, tod_sec_o and tod_ns_o are 0, and rd_valid_o is 0. rd_valid_o is 0 in any cycle that follows a clock edge at which read_i was low.
- R2: A tick with no phase residual and no frequency correction adds NOM = (10^9 << FRAC_W) >> TICK_SHIFT to the fixed-point nanosecond value (FRAC_W fraction bits). tod_ns_o shows the integer part of that value.
- R3: A tick adds q >>> tc to the step, where q is the signed residual phase and tc is the time constant. The residual then becomes q - (q >>> tc).
- R4: A load (load_i high) is held pending and has no effect on the time outputs until the next tick. At that tick the loaded phase replaces the residual, and the loaded time constant and frequency take over. A tick in the same cycle as a load uses the earlier state.
- R5: The per-tick frequency increment equals freq >>> TICK_SHIFT. It is recomputed only at a tick that wraps the seconds, using the frequency in force after that tick. From reset it is 0.
- R6: When the nanosecond value reaches 10^9 ns, 10^9 ns is subtracted and tod_sec_o increments by one.
- R7: The total step of one tick is clamped to the range from 0 to one second minus one fractional LSB.
- R8: One cycle after read_i is high, rd_valid_o is 1. The returned time is the tick-aligned time sampled at that edge plus min(cycles_since_tick * NS_PER_CYC, floor(NOM >> FRAC_W)) ns. Any carry past 10^9 ns moves into the seconds.
- R9: If that candidate is earlier than the previously returned time, the previously returned time is returned again.
- R10: The cycles-since-tick counter restarts at 0 on a tick and otherwise counts each clock, saturating at its maximum. A read in the same cycle as a tick uses the pre-tick time and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle tick strobe |
| load_i | input | 1 | Load strobe for phase, frequency and time constant |
| load_phase_i | input | PH_W | Signed phase offset, ns with FRAC_W fraction bits |
| load_freq_i | input | PH_W | Signed frequency offset, ns per second with FRAC_W fraction bits |
| load_tc_i | input | SHIFT_W | Time constant as a right-shift amount |
| read_i | input | 1 | Read strobe |
| tod_sec_o | output | SEC_W | Tick-aligned seconds |
| tod_ns_o | output | 30 | Tick-aligned integer nanoseconds |
| rd_valid_o | output | 1 | Read result valid |
| rd_sec_o | output | SEC_W | Returned seconds |
| rd_ns_o | output | 30 | Returned nanoseconds |

## Verification
Every result lands one clock edge after the inputs that cause it. The time outputs change at the edge that samples a tick. The read result appears at the edge that samples the read strobe and is built from the state that existed just before that edge. A load shows up only at the first tick edge after it. The bench drives inputs on the falling edge and advances a reference model once per rising edge. It compares the outputs shortly after that rising edge, so every comparison is made exactly one register stage after its stimulus.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int NS_W = 30;
    localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

    function automatic logic [63:0] one_sec_fx(input int frac_w);
        return NS_PER_SEC << frac_w;
    endfunction
endpackage

// File: rtl/tod_tick_core.sv
module tod_tick_core #(
    parameter int SEC_W      = 32,
    parameter int FRAC_W     = 16,
    parameter int PH_W       = 48,
    parameter int SHIFT_W    = 5,
    parameter int TICK_SHIFT = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_i,
    input  logic                     load_i,
    input  logic signed [PH_W-1:0]   load_phase_i,
    input  logic signed [PH_W-1:0]   load_freq_i,
    input  logic [SHIFT_W-1:0]       load_tc_i,
    output logic [SEC_W-1:0]         sec_o,
    output logic [tod_pkg::NS_W-1:0] ns_o
);
    localparam int          NSF_W   = tod_pkg::NS_W + FRAC_W;
    localparam logic [63:0] SEC_FX  = tod_pkg::one_sec_fx(FRAC_W);
    localparam logic [63:0] NOM_INC = SEC_FX >> TICK_SHIFT;
    localparam logic signed [63:0] STEP_MAX = $signed(SEC_FX - 64'd1);

    typedef struct packed {
        logic [SEC_W-1:0]       sec;
        logic [NSF_W-1:0]       ns;
        logic signed [PH_W-1:0] resid;
        logic signed [PH_W-1:0] freq;
        logic signed [PH_W-1:0] finc;
        logic [SHIFT_W-1:0]     tc;
        logic                   pend;
        logic signed [PH_W-1:0] pend_ph;
        logic signed [PH_W-1:0] pend_fr;
        logic [SHIFT_W-1:0]     pend_tc;
    } core_t;

    core_t cur_q, cur_d;

    logic signed [PH_W-1:0] ph_use, fr_use, slew;
    logic [SHIFT_W-1:0]     tc_use;
    logic signed [63:0]     step;
    logic [63:0]            sum;

    function automatic logic signed [63:0] sx(input logic signed [PH_W-1:0] v);
        return {{(64-PH_W){v[PH_W-1]}}, v};
    endfunction

    always_comb begin
        cur_d  = cur_q;
        ph_use = cur_q.pend ? cur_q.pend_ph : cur_q.resid;
        fr_use = cur_q.pend ? cur_q.pend_fr : cur_q.freq;
        tc_use = cur_q.pend ? cur_q.pend_tc : cur_q.tc;
        slew   = ph_use >>> tc_use;
        step   = $signed(NOM_INC) + sx(slew) + sx(cur_q.finc);
        if (step < 64'sd0) begin
            step = 64'sd0;
        end else if (step > STEP_MAX) begin
            step = STEP_MAX;
        end
        sum = 64'(cur_q.ns) + $unsigned(step);

        if (tick_i) begin
            cur_d.resid = ph_use - slew;
            cur_d.freq  = fr_use;
            cur_d.tc    = tc_use;
            cur_d.pend  = 1'b0;
            if (sum >= SEC_FX) begin
                cur_d.ns   = NSF_W'(sum - SEC_FX);
                cur_d.sec  = cur_q.sec + SEC_W'(1);
                cur_d.finc = fr_use >>> TICK_SHIFT;
            end else begin
                cur_d.ns = NSF_W'(sum);
            end
        end

        if (load_i) begin
            cur_d.pend    = 1'b1;
            cur_d.pend_ph = load_phase_i;
            cur_d.pend_fr = load_freq_i;
            cur_d.pend_tc = load_tc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign sec_o = cur_q.sec;
    assign ns_o  = cur_q.ns[NSF_W-1:FRAC_W];

    // R6
    ns_range_chk: assert property (@(posedge clk) disable iff (rst)
        64'(cur_q.ns) < SEC_FX);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(cur_q.ns) && $stable(cur_q.sec)));

    // R6
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cur_q.sec == $past(cur_q.sec) || cur_q.sec == $past(cur_q.sec) + SEC_W'(1)));

    // R3
    resid_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !cur_q.pend && !cur_q.resid[PH_W-1])
        |=> (!cur_q.resid[PH_W-1] && cur_q.resid <= $past(cur_q.resid)));
endmodule

// File: rtl/tod_interp.sv
module tod_interp #(
    parameter int CYC_W      = 20,
    parameter int NS_PER_CYC = 20,
    parameter int FRAC_W     = 16,
    parameter int TICK_SHIFT = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_i,
    output logic [tod_pkg::NS_W-1:0] interp_ns_o
);
    localparam logic [63:0] TICK_NS =
        (tod_pkg::one_sec_fx(FRAC_W) >> TICK_SHIFT) >> FRAC_W;
    localparam logic [CYC_W-1:0] CYC_MAX = '1;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
    } cnt_t;

    cnt_t        cnt_q, cnt_d;
    logic [63:0] scaled;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) begin
            cnt_d.cyc = '0;
        end else if (cnt_q.cyc != CYC_MAX) begin
            cnt_d.cyc = cnt_q.cyc + CYC_W'(1);
        end
        scaled = 64'(cnt_q.cyc) * 64'(NS_PER_CYC);
        if (scaled > TICK_NS) begin
            scaled = TICK_NS;
        end
        interp_ns_o = tod_pkg::NS_W'(scaled);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R10
    cyc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (interp_ns_o == '0));
endmodule

// File: rtl/tod_read_port.sv
module tod_read_port #(
    parameter int SEC_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     read_i,
    input  logic [SEC_W-1:0]         base_sec_i,
    input  logic [tod_pkg::NS_W-1:0] base_ns_i,
    input  logic [tod_pkg::NS_W-1:0] interp_ns_i,
    output logic                     rd_valid_o,
    output logic [SEC_W-1:0]         rd_sec_o,
    output logic [tod_pkg::NS_W-1:0] rd_ns_o
);
    localparam int NS_W = tod_pkg::NS_W;
    localparam logic [NS_W:0] SEC_NS = (NS_W+1)'(tod_pkg::NS_PER_SEC);

    typedef struct packed {
        logic             vld;
        logic [SEC_W-1:0] out_sec;
        logic [NS_W-1:0]  out_ns;
        logic [SEC_W-1:0] last_sec;
        logic [NS_W-1:0]  last_ns;
    } rd_t;

    rd_t              rd_q, rd_d;
    logic [NS_W:0]    ns_sum;
    logic [SEC_W-1:0] cand_sec;
    logic [NS_W-1:0]  cand_ns;
    logic             behind;

    always_comb begin
        rd_d     = rd_q;
        ns_sum   = {1'b0, base_ns_i} + {1'b0, interp_ns_i};
        cand_sec = base_sec_i;
        cand_ns  = ns_sum[NS_W-1:0];
        if (ns_sum >= SEC_NS) begin
            cand_sec = base_sec_i + SEC_W'(1);
            cand_ns  = NS_W'(ns_sum - SEC_NS);
        end
        behind = (cand_sec < rd_q.last_sec) ||
                 ((cand_sec == rd_q.last_sec) && (cand_ns < rd_q.last_ns));
        if (behind) begin
            cand_sec = rd_q.last_sec;
            cand_ns  = rd_q.last_ns;
        end
        rd_d.vld = read_i;
        if (read_i) begin
            rd_d.out_sec  = cand_sec;
            rd_d.out_ns   = cand_ns;
            rd_d.last_sec = cand_sec;
            rd_d.last_ns  = cand_ns;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.vld;
    assign rd_sec_o   = rd_q.out_sec;
    assign rd_ns_o    = rd_q.out_ns;

    // R8
    rd_ns_range_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> ({1'b0, rd_ns_o} < SEC_NS));

    // R1
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !read_i |=> !rd_valid_o);
endmodule

// File: rtl/tod_disc_clock.sv
module tod_disc_clock #(
    parameter int SEC_W      = 32,
    parameter int FRAC_W     = 16,
    parameter int PH_W       = 32 + FRAC_W,
    parameter int SHIFT_W    = 5,
    parameter int TICK_SHIFT = 10,
    parameter int CYC_W      = 20,
    parameter int NS_PER_CYC = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_i,
    input  logic                     load_i,
    input  logic [PH_W-1:0]          load_phase_i,
    input  logic [PH_W-1:0]          load_freq_i,
    input  logic [SHIFT_W-1:0]       load_tc_i,
    input  logic                     read_i,
    output logic [SEC_W-1:0]         tod_sec_o,
    output logic [tod_pkg::NS_W-1:0] tod_ns_o,
    output logic                     rd_valid_o,
    output logic [SEC_W-1:0]         rd_sec_o,
    output logic [tod_pkg::NS_W-1:0] rd_ns_o
);
    logic [tod_pkg::NS_W-1:0] interp_ns;

    tod_tick_core #(
        .SEC_W(SEC_W), .FRAC_W(FRAC_W), .PH_W(PH_W),
        .SHIFT_W(SHIFT_W), .TICK_SHIFT(TICK_SHIFT)
    ) u_core (
        .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
        .load_phase_i($signed(load_phase_i)), .load_freq_i($signed(load_freq_i)),
        .load_tc_i(load_tc_i), .sec_o(tod_sec_o), .ns_o(tod_ns_o)
    );

    tod_interp #(
        .CYC_W(CYC_W), .NS_PER_CYC(NS_PER_CYC),
        .FRAC_W(FRAC_W), .TICK_SHIFT(TICK_SHIFT)
    ) u_interp (
        .clk(clk), .rst(rst), .tick_i(tick_i), .interp_ns_o(interp_ns)
    );

    tod_read_port #(
        .SEC_W(SEC_W)
    ) u_read (
        .clk(clk), .rst(rst), .read_i(read_i),
        .base_sec_i(tod_sec_o), .base_ns_i(tod_ns_o), .interp_ns_i(interp_ns),
        .rd_valid_o(rd_valid_o), .rd_sec_o(rd_sec_o), .rd_ns_o(rd_ns_o)
    );
endmodule

// File: tb/sim_tod_disc_clock.sv
module sim_tod_disc_clock;
    localparam int  FRAC = 16;
    localparam int  TSH  = 10;
    localparam longint ONE   = 64'd1_000_000_000 << FRAC;
    localparam longint NOM   = ONE >>> TSH;
    localparam longint TNS   = NOM >>> FRAC;
    localparam longint CYMAX = (64'd1 << 20) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0, load_i = 1'b0, read_i = 1'b0;
    logic [47:0] load_phase_i = '0, load_freq_i = '0;
    logic [4:0]  load_tc_i = '0;
    logic [31:0] tod_sec_o, rd_sec_o;
    logic [29:0] tod_ns_o, rd_ns_o;
    logic        rd_valid_o;

    int total = 0;
    int bad = 0;

    longint m_sec = 0, m_ns = 0, m_q = 0, m_f = 0, m_finc = 0, m_cyc = 0;
    longint m_tc = 0, m_pq = 0, m_pf = 0, m_ptc = 0, m_lsec = 0, m_lns = 0;
    bit     m_pend = 0;

    always #10 clk = ~clk;

    tod_disc_clock u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
        .load_phase_i(load_phase_i), .load_freq_i(load_freq_i), .load_tc_i(load_tc_i),
        .read_i(read_i), .tod_sec_o(tod_sec_o), .tod_ns_o(tod_ns_o),
        .rd_valid_o(rd_valid_o), .rd_sec_o(rd_sec_o), .rd_ns_o(rd_ns_o)
    );

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic longint step_of(longint q, longint tc, longint finc);
        longint s = NOM + (q >>> tc) + finc;
        if (s < 0) s = 0;
        if (s > ONE - 1) s = ONE - 1;
        return s;
    endfunction

    task automatic cycle(bit tk, bit ld, longint ph, longint fr, int tc, bit rd, string tag);
        longint esec = 0, ens = 0, ip, q, f, t, s;
        @(negedge clk);
        tick_i = tk; load_i = ld; read_i = rd;
        load_phase_i = 48'(ph); load_freq_i = 48'(fr); load_tc_i = 5'(tc);
        if (rd) begin
            ip = m_cyc * 20;
            if (ip > TNS) ip = TNS;
            ens = (m_ns >>> FRAC) + ip;
            esec = m_sec;
            if (ens >= 1000000000) begin ens -= 1000000000; esec++; end
            if (esec < m_lsec || (esec == m_lsec && ens < m_lns)) begin
                esec = m_lsec; ens = m_lns;
            end
            m_lsec = esec; m_lns = ens;
        end
        if (tk) begin
            q = m_pend ? m_pq : m_q;
            f = m_pend ? m_pf : m_f;
            t = m_pend ? m_ptc : m_tc;
            s = step_of(q, t, m_finc);
            m_q = q - (q >>> t); m_f = f; m_tc = t; m_pend = 0;
            m_ns += s;
            if (m_ns >= ONE) begin m_ns -= ONE; m_sec++; m_finc = f >>> TSH; end
            m_cyc = 0;
        end else if (m_cyc != CYMAX) begin
            m_cyc++;
        end
        if (ld) begin m_pend = 1; m_pq = ph; m_pf = fr; m_ptc = tc; end
        @(posedge clk); #1;
        chk({tag, " sec"}, longint'(tod_sec_o), m_sec);
        chk({tag, " ns"}, longint'(tod_ns_o), m_ns >>> FRAC);
        chk("R1/R8 valid", longint'(rd_valid_o), longint'(rd));
        if (rd) begin
            chk("R8/R9 rd_sec", longint'(rd_sec_o), esec);
            chk("R8/R9 rd_ns", longint'(rd_ns_o), ens);
        end
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(20 * 190000);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint hold_sec, hold_ns;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 reset sec", longint'(tod_sec_o), 0);
        chk("R1 reset ns", longint'(tod_ns_o), 0);
        chk("R1 reset valid", longint'(rd_valid_o), 0);

        // R2 nominal ticks, R10 counter restart and read in the tick cycle
        cycle(1, 0, 0, 0, 0, 0, "R2");
        chk("R2 first tick ns", longint'(tod_ns_o), TNS);
        idle(5, "R4");
        cycle(0, 0, 0, 0, 0, 1, "R10");
        cycle(1, 0, 0, 0, 0, 1, "R10");
        cycle(0, 0, 0, 0, 0, 1, "R10");

        // R4 load waits for tick; R3 slew of the loaded residual
        cycle(0, 1, 64'sd1000 << FRAC, 0, 2, 0, "R4");
        idle(3, "R4");
        cycle(1, 0, 0, 0, 0, 0, "R3");
        cycle(1, 0, 0, 0, 0, 0, "R3");
        cycle(1, 1, -(64'sd500 << FRAC), 0, 1, 0, "R4");
        cycle(1, 0, 0, 0, 0, 0, "R3");

        // R6 reach a rollover; R5 frequency used only after it
        cycle(0, 1, 0, 64'sd1024000 << FRAC, 3, 0, "R5");
        for (int i = 0; i < 1100; i++) cycle(1, 0, 0, 0, 0, 0, "R5/R6");
        chk("R6 rolled", longint'(tod_sec_o), 1);

        // R7 negative step clamps to zero
        hold_ns = m_ns;
        cycle(0, 1, -(64'sd2000000 << FRAC), 0, 0, 0, "R7");
        cycle(1, 0, 0, 0, 0, 0, "R7");
        chk("R7 no backstep", m_ns, hold_ns);
        // R7 large step clamps below one second
        cycle(0, 1, 64'sd1500000000 << FRAC, 0, 0, 0, "R7");
        cycle(1, 0, 0, 0, 0, 0, "R7");
        cycle(0, 1, 0, 0, 4, 0, "R7");
        cycle(1, 0, 0, 0, 0, 0, "R7");

        // R8 interpolation cap after a long gap
        idle(50000, "R4");
        cycle(0, 0, 0, 0, 0, 1, "R8");

        // R9 monotonic read after a short tick
        cycle(1, 0, 0, 0, 0, 0, "R9");
        idle(40000, "R4");
        cycle(0, 0, 0, 0, 0, 1, "R9");
        hold_sec = longint'(rd_sec_o); hold_ns = longint'(rd_ns_o);
        cycle(0, 1, -(64'sd900000 << FRAC), 0, 0, 0, "R9");
        cycle(1, 0, 0, 0, 0, 0, "R9");
        cycle(0, 0, 0, 0, 0, 1, "R9");
        chk("R9 held sec", longint'(rd_sec_o), hold_sec);
        chk("R9 held ns", longint'(rd_ns_o), hold_ns);

        // random mix covering R2..R10
        for (int i = 0; i < 20000; i++) begin
            bit tk = ($urandom_range(7) == 0);
            bit rd = ($urandom_range(3) == 0);
            bit ld = ($urandom_range(63) == 0);
            longint ph = (longint'($urandom_range(2000000)) - 1000000) <<< FRAC;
            longint fr = (longint'($urandom_range(1000000)) - 500000) <<< FRAC;
            ph += longint'($urandom_range(65535));
            cycle(tk, ld, ph, fr, int'($urandom_range(8)), rd, "R3/R5 rnd");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule